// File: doc/BRIEF.md
# External Bus Sequencer with Per-Region Data Width

This block sits between a processor's internal memory port and an external asynchronous memory bus. The requester holds a request carrying an address, write data, a byte/word flag and a read/write flag. The block answers with a one-cycle acknowledge, and with read data when the request was a read. It decodes the upper address bits against six programmable chip-select regions, each one 1 MB in size inside a 16 MB space. It then runs one or two bus cycles shaped by the width of the selected region.

A 16-bit region takes each access in a single cycle. Writes use the two byte-lane enables to pick the lane, and every read fetches the whole aligned word. An 8-bit region splits each read and each word write into two byte cycles back to back: the even address first and the odd address second. The chip select stays asserted between the two. An external wait input holds the strobe for extra cycles.

Each bus cycle has a fixed shape. First comes one setup clock, in which the address, the chip select and the lane enables are valid and the strobe is idle. Then the strobe is active for at least one clock. A small configuration port sets each region's base, enable and width.

Top module: `extbus_ctrl`

## Requirements
- R1: After reset every chip select, both strobes and both lane enables are inactive (high), ack is 0 and bus_oe is 0. Only region 0 is enabled out of reset, with base 0 and a 16-bit width, so addresses 0x000000 to 0x0FFFFF select bus_cs_n[0].
- R2: A clock edge with cfg_we=1 loads region cfg_idx with base cfg_base, enable cfg_en and width cfg_wide, where 1 means 16-bit. A request selects each enabled region whose base equals req_addr[23:20], and when several match the lowest index wins. Only the winner's bus_cs_n bit is driven low, for the whole transfer. A request that matches no region still runs, with all chip selects high and a 16-bit width.
- R3: A request accepted at clock edge k drives the address phase from edge k to k+1, with the strobe inactive. The strobe is active from edge k+1. Without wait, a single-cycle transfer raises ack at edge k+2. Only one of bus_rd_n and bus_wr_n is ever low.
- R4: At each clock edge that ends a strobe clock, bus_wait=1 keeps the strobe active for one more clock. This delays that byte cycle, and ack, by one clock per waited edge.
- R5: A read from a 16-bit region drives bus_addr[0]=0 and both lane enables low. rdata is the bus_din value sampled at the edge that ends the strobe.
- R6: For a 16-bit region, a byte write keeps the requested address and asserts one lane enable. With address bit 0 = 0 it drives bus_ble_n low and wdata[7:0] on bus_dout[7:0]. With address bit 0 = 1 it drives bus_bhe_n low and wdata[7:0] on bus_dout[15:8]. A word write drives bus_addr[0]=0, both lane enables low and bus_dout = wdata.
- R7: For an 8-bit region, a read or a word write runs two byte cycles on lane 0, with bus_ble_n low and bus_bhe_n high. The first cycle uses the address with bit 0 cleared and the low byte. The second uses that address plus one and the high byte. A setup clock separates the two strobes, and the chip select stays low throughout. ack rises at edge k+4 without wait. Read data is {second byte, first byte}, each taken from bus_din[7:0].
- R8: For an 8-bit region, a byte write runs one cycle at the requested address, with wdata[7:0] on bus_dout[7:0] and only bus_ble_n low.
- R9: ack is high for exactly one clock per transfer. A request is not accepted in the clock where ack is high. The requester holds req and its fields stable until it sees ack.
- R10: bus_oe is high from the address phase to the end of a write transfer, and low during read transfers and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for one region's settings |
| cfg_idx | input | 3 | Region to load |
| cfg_base | input | 4 | Region base, compared with address bits 23:20 |
| cfg_en | input | 1 | Region enable |
| cfg_wide | input | 1 | Region width: 1 = 16-bit, 0 = 8-bit |
| req | input | 1 | Transfer request, held until ack |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read word, valid with ack |
| bus_addr | output | 24 | External address |
| bus_cs_n | output | 6 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ble_n | output | 1 | Low byte lane enable, active low |
| bus_bhe_n | output | 1 | High byte lane enable, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_oe | output | 1 | Data driver enable for writes |
| bus_din | input | 16 | Read data from the bus |
| bus_wait | input | 1 | Stretches the active strobe |

## Verification
A single-cycle transfer accepted at edge k acknowledges at edge k+2. A split transfer acknowledges at edge k+4. Each edge that samples wait high adds one clock, and it does so for each byte cycle of a split.

The bench raises req just after an edge and counts falling edges while req is high. It expects ack at count 4 plus the waits for a single cycle, and at count 6 plus twice the waits for a split.

The bus model adds the waits itself: it raises wait on the falling edges of the first strobe clocks of every byte cycle. At the first falling edge of each strobe it compares address, chip selects, lanes, driver enable and write data with the queued expectations.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT,
    ST_SECOND
  } bus_state_e;

  // An 8-bit region needs two byte cycles for every read and every word write.
  function automatic logic needs_split(input logic wide, input logic write, input logic word);
    return !wide && (!write || word);
  endfunction

  // Active-high lane mask {high, low} for the current cycle.
  function automatic logic [1:0] lane_mask(input logic wide, input logic write,
                                           input logic word, input logic a0);
    if (!wide)
      return 2'b01;
    if (write && !word)
      return a0 ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction

  // Address bit 0 driven on the bus.
  function automatic logic bus_a0(input logic wide, input logic write, input logic word,
                                  input logic a0, input logic second);
    if (needs_split(wide, write, word))
      return second;
    if (wide && (!write || word))
      return 1'b0;
    return a0;
  endfunction

endpackage

// File: rtl/extbus_csdec.sv
module extbus_csdec #(
  parameter int NUM_CS = 6,
  parameter int BASE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_idx,
  input  logic [BASE_W-1:0]         cfg_base,
  input  logic                      cfg_en,
  input  logic                      cfg_wide,
  input  logic [BASE_W-1:0]         look_base,
  output logic [NUM_CS-1:0]         hit_cs,
  output logic                      hit_wide
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic [NUM_CS-1:0] raw_hit;
  logic [NUM_CS-1:0] wide_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_rgn
    localparam bit BOOT_ON = (g == 0);
    logic [BASE_W-1:0] base_q;
    logic              en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q    <= '0;
        en_q      <= BOOT_ON;
        wide_q[g] <= BOOT_ON;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        base_q    <= cfg_base;
        en_q      <= cfg_en;
        wide_q[g] <= cfg_wide;
      end
    end

    assign raw_hit[g] = en_q && (base_q == look_base);
  end

  // Lowest matching index wins.
  always_comb begin
    hit_cs   = '0;
    hit_wide = 1'b1;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        hit_cs    = '0;
        hit_cs[i] = 1'b1;
        hit_wide  = wide_q[i];
      end
    end
  end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [NUM_CS-1:0] hit_cs,
  input  logic              hit_wide,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ble_n,
  output logic              bus_bhe_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_wait,
  output logic              cyc_busy,
  output logic              cyc_wide,
  output logic              cyc_word
);
  localparam int LANE_W = DATA_W / 2;

  bus_state_e        st;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] wd_q;
  logic              word_q, wr_q, wide_q, half_q, ack_q;
  logic [NUM_CS-1:0] cs_q;
  logic [LANE_W-1:0] lo_q;
  logic [DATA_W-1:0] rdata_q;

  logic              split, strobe;
  logic [1:0]        lanes;
  logic [LANE_W-1:0] byte_out;

  assign split  = needs_split(wide_q, wr_q, word_q);
  assign strobe = (st == ST_DATA) || (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      word_q  <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b1;
      half_q  <= 1'b0;
      cs_q    <= '0;
      lo_q    <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (req && !ack_q) begin
          a_q    <= req_addr;
          wd_q   <= req_wdata;
          word_q <= req_word;
          wr_q   <= req_write;
          cs_q   <= hit_cs;
          wide_q <= hit_wide;
          half_q <= 1'b0;
          st     <= ST_ADDR;
        end
        ST_ADDR, ST_SECOND: st <= ST_DATA;
        ST_DATA, ST_WAIT: begin
          if (bus_wait) begin
            st <= ST_WAIT;
          end else if (split && !half_q) begin
            lo_q   <= bus_din[LANE_W-1:0];
            half_q <= 1'b1;
            st     <= ST_SECOND;
          end else begin
            rdata_q <= split ? {bus_din[LANE_W-1:0], lo_q} : bus_din;
            ack_q   <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lanes    = lane_mask(wide_q, wr_q, word_q, a_q[0]);
    byte_out = half_q ? wd_q[DATA_W-1:LANE_W] : wd_q[LANE_W-1:0];
  end

  assign cyc_busy  = (st != ST_IDLE);
  assign cyc_wide  = wide_q;
  assign cyc_word  = word_q;
  assign bus_addr  = {a_q[ADDR_W-1:1], bus_a0(wide_q, wr_q, word_q, a_q[0], half_q)};
  assign bus_cs_n  = cyc_busy ? ~cs_q : '1;
  assign bus_ble_n = !(cyc_busy && lanes[0]);
  assign bus_bhe_n = !(cyc_busy && lanes[1]);
  assign bus_rd_n  = !(strobe && !wr_q);
  assign bus_wr_n  = !(strobe && wr_q);
  assign bus_oe    = cyc_busy && wr_q;
  assign bus_dout  = (wide_q && word_q) ? wd_q : {byte_out, byte_out};
  assign ack       = ack_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24,
  parameter int RGN_W  = 20,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_idx,
  input  logic [ADDR_W-RGN_W-1:0]   cfg_base,
  input  logic                      cfg_en,
  input  logic                      cfg_wide,
  input  logic                      req,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      req_word,
  input  logic                      req_write,
  output logic                      ack,
  output logic [DATA_W-1:0]         rdata,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [NUM_CS-1:0]         bus_cs_n,
  output logic                      bus_rd_n,
  output logic                      bus_wr_n,
  output logic                      bus_ble_n,
  output logic                      bus_bhe_n,
  output logic [DATA_W-1:0]         bus_dout,
  output logic                      bus_oe,
  input  logic [DATA_W-1:0]         bus_din,
  input  logic                      bus_wait
);
  localparam int BASE_W = ADDR_W - RGN_W;

  logic [NUM_CS-1:0] hit_cs;
  logic              hit_wide;
  logic              cyc_busy, cyc_wide, cyc_word;

  extbus_csdec #(.NUM_CS(NUM_CS), .BASE_W(BASE_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_base (cfg_base),
    .cfg_en   (cfg_en),
    .cfg_wide (cfg_wide),
    .look_base(req_addr[ADDR_W-1:RGN_W]),
    .hit_cs   (hit_cs),
    .hit_wide (hit_wide)
  );

  extbus_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_word (req_word),
    .req_write(req_write),
    .hit_cs   (hit_cs),
    .hit_wide (hit_wide),
    .ack      (ack),
    .rdata    (rdata),
    .bus_addr (bus_addr),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_ble_n(bus_ble_n),
    .bus_bhe_n(bus_bhe_n),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe),
    .bus_din  (bus_din),
    .bus_wait (bus_wait),
    .cyc_busy (cyc_busy),
    .cyc_wide (cyc_wide),
    .cyc_word (cyc_word)
  );
endmodule

// File: rtl/extbus_ctrl_chk.sv
module extbus_ctrl_chk #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_ble_n,
  input logic              bus_bhe_n,
  input logic              bus_oe,
  input logic              bus_wait,
  input logic              cyc_busy,
  input logic              cyc_wide,
  input logic              cyc_word
);
  logic strobe_n;
  assign strobe_n = bus_rd_n & bus_wr_n;

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R3
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> ($stable(bus_addr) && $stable(bus_cs_n)));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && bus_wait) |=> !strobe_n);

  // R5
  rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && cyc_wide) |-> (!bus_ble_n && !bus_bhe_n && !bus_addr[0]));

  // R6
  byte_wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && cyc_wide && !cyc_word) |-> (bus_ble_n != bus_bhe_n));

  // R7
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && !cyc_wide) |-> (bus_bhe_n && !bus_ble_n));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n |-> bus_oe) and (!bus_rd_n |-> !bus_oe));
endmodule

bind extbus_ctrl extbus_ctrl_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .bus_addr (bus_addr),
  .bus_cs_n (bus_cs_n),
  .bus_rd_n (bus_rd_n),
  .bus_wr_n (bus_wr_n),
  .bus_ble_n(bus_ble_n),
  .bus_bhe_n(bus_bhe_n),
  .bus_oe   (bus_oe),
  .bus_wait (bus_wait),
  .cyc_busy (cyc_busy),
  .cyc_wide (cyc_wide),
  .cyc_word (cyc_word)
);

// File: tb/extbus_ctrl_test.sv
`timescale 1ns/1ps
module extbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_base = '0;
  logic        cfg_en = 1'b0, cfg_wide = 1'b0;
  logic        req = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_word = 1'b0, req_write = 1'b0;
  logic        ack;
  logic [15:0] rdata;
  logic [23:0] bus_addr;
  logic [5:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n, bus_ble_n, bus_bhe_n, bus_oe;
  logic [15:0] bus_dout, bus_din;
  logic        bus_wait = 1'b0;

  extbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_en(cfg_en), .cfg_wide(cfg_wide), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_word(req_word), .req_write(req_write), .ack(ack),
    .rdata(rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ble_n(bus_ble_n), .bus_bhe_n(bus_bhe_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_wait(bus_wait)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [23:0] a; logic [5:0] csn; logic [1:0] ln_n; logic wr;
    logic [15:0] m; logic [15:0] d;
  } bexp_t;
  typedef struct packed { logic rd; logic [15:0] d; logic [7:0] lat; } rexp_t;

  bexp_t bq[$];
  rexp_t rq[$];
  int    nchk = 0, nerr = 0;
  string cur_tag = "R1";
  int    wait_cfg = 0, wcnt = 0, since = 0;
  bit    prev_strobe = 0, prev_ack = 0, done = 0;

  function automatic logic [15:0] mem_fn(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  assign bus_din = mem_fn(bus_addr);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Bus model: wait_cfg wait edges per byte cycle.
  always @(negedge clk) begin
    if (!(bus_rd_n && bus_wr_n)) begin
      bus_wait <= (wcnt < wait_cfg);
      wcnt     <= wcnt + 1;
    end else begin
      bus_wait <= 1'b0;
      wcnt     <= 0;
    end
  end

  // Monitor: bus cycles and responses against the queues.
  always @(negedge clk) begin
    bit    strobe;
    bexp_t be;
    rexp_t re;
    strobe = !(bus_rd_n && bus_wr_n);
    if (rst_n && strobe && !prev_strobe) begin
      if (bq.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected bus cycle", {8'h0, bus_addr}, 32'h0);
      end else begin
        be = bq.pop_front();
        chk(bus_addr == be.a, cur_tag, "bus_addr", {8'h0, bus_addr}, {8'h0, be.a});
        chk(bus_cs_n == be.csn, cur_tag, "bus_cs_n", {26'h0, bus_cs_n}, {26'h0, be.csn});
        chk({bus_bhe_n, bus_ble_n} == be.ln_n, cur_tag, "lanes_n",
            {30'h0, bus_bhe_n, bus_ble_n}, {30'h0, be.ln_n});
        chk(!bus_wr_n == be.wr, cur_tag, "strobe kind", {31'h0, !bus_wr_n}, {31'h0, be.wr});
        chk(bus_oe == be.wr, "R10", "bus_oe", {31'h0, bus_oe}, {31'h0, be.wr});
        if (be.wr)
          chk((bus_dout & be.m) == be.d, cur_tag, "bus_dout",
              {16'h0, bus_dout & be.m}, {16'h0, be.d});
      end
    end
    prev_strobe = strobe;
    if (req) since++;
    if (rst_n && prev_ack && ack)
      chk(1'b0, "R9", "ack longer than one clock", 32'd1, 32'd0);
    if (rst_n && ack) begin
      if (rq.size() == 0) begin
        chk(1'b0, "R9", "unexpected ack", 32'd1, 32'd0);
      end else begin
        re = rq.pop_front();
        chk(since == int'(re.lat), "R3", "ack latency", since, {24'h0, re.lat});
        if (re.rd)
          chk(rdata == re.d, cur_tag, "rdata", {16'h0, rdata}, {16'h0, re.d});
      end
      since = 0;
    end
    prev_ack = ack;
  end

  task automatic set_rgn(input int idx, input logic [3:0] base, input bit en, input bit wide);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_en = en; cfg_wide = wide;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  // Driver: compute the expected bus cycles and response, then run the request.
  task automatic xfer(input string tag, input logic [23:0] a, input logic [15:0] wd,
                      input bit word, input bit wr, input bit wide,
                      input logic [5:0] csn, input int waits);
    bit          split;
    logic [23:0] e;
    rexp_t       re;
    split = !wide && (!wr || word);
    e = {a[23:1], 1'b0};
    re.rd = !wr;
    if (split) begin
      bq.push_back('{e, csn, 2'b10, wr, 16'h00FF, {8'h00, wd[7:0]}});
      bq.push_back('{e + 24'd1, csn, 2'b10, wr, 16'h00FF, {8'h00, wd[15:8]}});
      re.d   = {mem_fn(e + 24'd1)[7:0], mem_fn(e)[7:0]};
      re.lat = 8'(6 + 2 * waits);
    end else begin
      if (!wide)
        bq.push_back('{a, csn, 2'b10, wr, 16'h00FF, {8'h00, wd[7:0]}});
      else if (wr && !word)
        bq.push_back(a[0] ? '{a, csn, 2'b01, wr, 16'hFF00, {wd[7:0], 8'h00}}
                          : '{a, csn, 2'b10, wr, 16'h00FF, {8'h00, wd[7:0]}});
      else
        bq.push_back('{e, csn, 2'b00, wr, 16'hFFFF, wd});
      re.d   = mem_fn(e);
      re.lat = 8'(4 + waits);
    end
    rq.push_back(re);
    cur_tag = tag;
    wait_cfg = waits;
    @(posedge clk); #2;
    req = 1'b1; req_addr = a; req_wdata = wd; req_word = word; req_write = wr;
    do @(negedge clk); while (!ack);
    @(posedge clk); #2;
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk(bq.size() == 0 && rq.size() == 0, tag, "all expected cycles seen",
        bq.size() + rq.size(), 32'd0);
    bq.delete();
    rq.delete();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 idle outputs after reset
    chk(bus_cs_n == 6'h3F && bus_rd_n && bus_wr_n && bus_ble_n && bus_bhe_n
        && !ack && !bus_oe, "R1", "reset outputs",
        {20'h0, bus_cs_n, bus_rd_n, bus_wr_n, bus_ble_n, bus_bhe_n, ack, bus_oe},
        {20'h0, 6'h3F, 4'hF, 2'b00});

    // Region 0 from reset: 16-bit, base 0
    xfer("R1", 24'h000123, 16'h0, 1'b0, 1'b0, 1'b1, 6'b111110, 0);
    xfer("R5", 24'h000456, 16'h0, 1'b1, 1'b0, 1'b1, 6'b111110, 0);
    xfer("R6", 24'h000456, 16'hBEEF, 1'b1, 1'b1, 1'b1, 6'b111110, 0);
    xfer("R6", 24'h000201, 16'h0077, 1'b0, 1'b1, 1'b1, 6'b111110, 0);
    xfer("R6", 24'h000200, 16'h0066, 1'b0, 1'b1, 1'b1, 6'b111110, 0);

    // Region 1 as 8-bit at 0x2xxxxx
    set_rgn(1, 4'h2, 1'b1, 1'b0);
    xfer("R7", 24'h200031, 16'h0, 1'b0, 1'b0, 1'b0, 6'b111101, 0);
    xfer("R7", 24'h200010, 16'h0, 1'b1, 1'b0, 1'b0, 6'b111101, 0);
    xfer("R7", 24'h200040, 16'h1234, 1'b1, 1'b1, 1'b0, 6'b111101, 0);
    xfer("R8", 24'h200045, 16'h00AB, 1'b0, 1'b1, 1'b0, 6'b111101, 0);

    // Wait stretching on single and split transfers
    xfer("R4", 24'h000300, 16'h0, 1'b1, 1'b0, 1'b1, 6'b111110, 2);
    xfer("R4", 24'h200050, 16'hC3D4, 1'b1, 1'b1, 1'b0, 6'b111101, 1);

    // Decode: no match, overlap priority, disable, high region
    xfer("R2", 24'h900000, 16'h0, 1'b1, 1'b0, 1'b1, 6'b111111, 0);
    set_rgn(2, 4'h0, 1'b1, 1'b0);
    xfer("R2", 24'h000010, 16'h0, 1'b1, 1'b0, 1'b1, 6'b111110, 0);
    set_rgn(0, 4'h0, 1'b0, 1'b1);
    xfer("R2", 24'h000010, 16'h0, 1'b1, 1'b0, 1'b0, 6'b111011, 0);
    set_rgn(1, 4'h2, 1'b0, 1'b0);
    xfer("R2", 24'h200000, 16'h0, 1'b1, 1'b0, 1'b1, 6'b111111, 0);
    set_rgn(5, 4'hF, 1'b1, 1'b1);
    xfer("R2", 24'hF00002, 16'h5A5A, 1'b1, 1'b1, 1'b1, 6'b011111, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule